// File: doc/BRIEF.md
# Random-Offset Wear-Leveling Remapper

This block sits between a requester and a word-addressed memory of `2**ADDR_W` words and spreads writes evenly over the physical array. Each access carries a logical address. The block adds a rotating offset to it, modulo the memory size, before the address reaches the memory port. A free-running period timer fires at a fixed interval. When it fires, the block draws a random nonzero step from a maximal-length LFSR. It then shifts the whole memory contents forward by that step, in place, through the same memory port. At the end it adds the step to the offset, so every logical address still sees its old data.

The in-place move uses only one carried data register. A step whose lowest set bit has weight `2**k` splits the address ring into `2**k` disjoint chains, and each chain is `2**(ADDR_W-k)` words long. For each chain the engine reads the head word and then walks the chain. At each link it reads the next word, writes the carried word there, and keeps the word it just read as the new carry. When the walk returns to the head, it writes the carry back to the head. Every word is read once and written once, and this also refreshes the stored data.

The engine is a state machine with eight states:
- `ST_IDLE`: normal access. It moves to `ST_DRAW` on the timer tick.
- `ST_DRAW`: draws a step. It stays in `ST_DRAW` and redraws while the drawn value is zero, and moves to `ST_HEAD_RD` once a nonzero step is latched.
- `ST_HEAD_RD`: reads the chain head. It then moves to `ST_HEAD_CAP`.
- `ST_HEAD_CAP`: captures the carry and points at head plus step. It then moves to `ST_WALK_RD`.
- `ST_WALK_RD`: reads the next link. It moves to `ST_WALK_WR`, or to `ST_TAIL_WR` when the pointer is back at the head.
- `ST_WALK_WR`: writes the carry, swaps in the read data and advances the pointer. It then returns to `ST_WALK_RD`.
- `ST_TAIL_WR`: closes the chain. It moves to `ST_HEAD_RD` for the next chain, or to `ST_COMMIT` after the last chain.
- `ST_COMMIT`: updates the offset. It then returns to `ST_IDLE`.

While the engine is outside `ST_IDLE`, requests are stalled.

Top module: `wl_remapper`

## Requirements
- R1: While idle, a request drives the memory port at once. `mem_en` equals `req_valid`, `mem_we` equals `req_write`, `mem_wdata` equals `req_wdata`, and `mem_addr` equals `(req_addr + offset) mod 2**ADDR_W`. The memory returns read data one cycle later, and `rd_data` passes it through.
- R2: `busy` rises at the PERIOD-th rising edge after reset is released. After each remap it rises again exactly PERIOD edges after the edge at which `busy` fell. The timer does not advance while `busy` is high.
- R3: While `busy` is high, `req_ready` is low and requests have no effect on memory. A request held across a remap is served in the first idle cycle.
- R4: The step used for a remap is never zero. A zero draw is discarded and a new value is drawn, so each remap changes the offset.
- R5: During one remap, every physical word is read exactly once and written exactly once. No two engine writes occur in consecutive cycles.
- R6: The data at physical address p moves to `(p + step) mod 2**ADDR_W`. The offset becomes `(offset + step) mod 2**ADDR_W`, so every logical read after a remap returns the data written before it.
- R7: The remap walks `2**k` chains, where k is the number of trailing zeros of the step. The chain index never leaves that range.
- R8: During reset and right after it, `busy` is 0, `mem_en` is 0 with no request, and the offset is 0.
- R9: The offset changes only at the edge where `busy` falls. `busy` stays high from the tick until the offset has been updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle (low during a remap) |
| rd_data | output | DATA_W | Read data, valid one cycle after a read request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Physical word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |
| busy | output | 1 | Remap in progress |

## Verification
A request changes the memory port in its own cycle, because the address path is combinational. Read data comes back on the next cycle. The bench therefore checks `mem_addr` at the falling edge where it drove the request, and checks `rd_data` one falling edge later. `busy` rises at the edge on which the timer counter holds PERIOD-1. The bench counts rising edges from reset release, and it compares that count at the first falling edge where `busy` is seen high against PERIOD, or against PERIOD plus the edge count at which `busy` fell. Read and write counts per physical word are collected on each rising edge while `busy` is high. They are compared only after `busy` has fallen.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAW,
        ST_HEAD_RD,
        ST_HEAD_CAP,
        ST_WALK_RD,
        ST_WALK_WR,
        ST_TAIL_WR,
        ST_COMMIT
    } wl_state_e;

    function automatic logic [31:0] lfsr_taps(input int width);
        case (width)
            8:       return 32'h0000_00B8;
            16:      return 32'h0000_B400;
            24:      return 32'h00E1_0000;
            default: return 32'h8020_0003;
        endcase
    endfunction

endpackage

// File: rtl/wl_lfsr.sv
module wl_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    import wl_pkg::*;

    localparam logic [WIDTH-1:0] TAPS  = WIDTH'(lfsr_taps(WIDTH));
    localparam logic [WIDTH-1:0] START = (WIDTH'(SEED) == '0) ? WIDTH'(1) : WIDTH'(SEED);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    generate
        if (WIDTH == 8 || WIDTH == 16 || WIDTH == 24 || WIDTH == 32) begin : g_galois
            always_comb begin
                state_d = state_q >> 1;
                if (state_q[0]) begin
                    state_d = state_d ^ TAPS;
                end
            end
        end else begin : g_unsupported
            always_comb begin
                state_d = {state_q[0] ^ state_q[WIDTH-1], state_q[WIDTH-1:1]};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= START;
        end else if (step) begin
            state_q <= state_d;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/wl_period_timer.sv
module wl_period_timer #(
    parameter int PERIOD = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/wl_rotate_engine.sv
module wl_rotate_engine #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [ADDR_W-1:0]        rnd,
    output logic                     rnd_step,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     eng_en,
    output logic                     eng_we,
    output logic [ADDR_W-1:0]        eng_addr,
    output logic [DATA_W-1:0]        eng_wdata,
    output logic                     commit,
    output logic [ADDR_W-1:0]        delta,
    output logic [ADDR_W-1:0]        chain_idx,
    output logic [ADDR_W-1:0]        chain_last,
    output wl_pkg::wl_state_e        state
);
    import wl_pkg::*;

    wl_state_e          state_q;
    wl_state_e          state_d;
    logic [ADDR_W-1:0]  delta_q;
    logic [ADDR_W-1:0]  last_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [DATA_W-1:0]  carry_q;
    logic [ADDR_W-1:0]  rnd_lowbit;

    assign rnd_lowbit = rnd & (~rnd + ADDR_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (tick) state_d = ST_DRAW;
            ST_DRAW:     if (rnd != '0) state_d = ST_HEAD_RD;
            ST_HEAD_RD:  state_d = ST_HEAD_CAP;
            ST_HEAD_CAP: state_d = ST_WALK_RD;
            ST_WALK_RD:  state_d = (ptr_q == idx_q) ? ST_TAIL_WR : ST_WALK_WR;
            ST_WALK_WR:  state_d = ST_WALK_RD;
            ST_TAIL_WR:  state_d = (idx_q == last_q) ? ST_COMMIT : ST_HEAD_RD;
            ST_COMMIT:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_en    = 1'b0;
        eng_we    = 1'b0;
        eng_addr  = idx_q;
        eng_wdata = carry_q;
        rnd_step  = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_DRAW:     rnd_step = 1'b1;
            ST_HEAD_RD:  eng_en = 1'b1;
            ST_HEAD_CAP: ;
            ST_WALK_RD: begin
                eng_en   = (ptr_q != idx_q);
                eng_addr = ptr_q;
            end
            ST_WALK_WR: begin
                eng_en   = 1'b1;
                eng_we   = 1'b1;
                eng_addr = ptr_q;
            end
            ST_TAIL_WR: begin
                eng_en = 1'b1;
                eng_we = 1'b1;
            end
            ST_COMMIT:   commit = 1'b1;
            default:     ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delta_q <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            ptr_q   <= '0;
            carry_q <= '0;
        end else begin
            unique case (state_q)
                ST_DRAW: begin
                    if (rnd != '0) begin
                        delta_q <= rnd;
                        last_q  <= rnd_lowbit - ADDR_W'(1);
                        idx_q   <= '0;
                    end
                end
                ST_HEAD_CAP: begin
                    carry_q <= mem_rdata;
                    ptr_q   <= idx_q + delta_q;
                end
                ST_WALK_WR: begin
                    carry_q <= mem_rdata;
                    ptr_q   <= ptr_q + delta_q;
                end
                ST_TAIL_WR: begin
                    if (idx_q != last_q) begin
                        idx_q <= idx_q + ADDR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign delta      = delta_q;
    assign chain_idx  = idx_q;
    assign chain_last = last_q;
    assign state      = state_q;

endmodule

// File: rtl/wl_remapper.sv
module wl_remapper #(
    parameter int          ADDR_W = 6,
    parameter int          DATA_W = 16,
    parameter int          PERIOD = 1000000,
    parameter int          LFSR_W = 16,
    parameter logic [31:0] SEED   = 32'h0000_ACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy
);
    import wl_pkg::*;

    logic [LFSR_W-1:0] lfsr_val;
    logic              rnd_step;
    logic              tick;
    logic              commit;
    logic              eng_en;
    logic              eng_we;
    logic [ADDR_W-1:0] eng_addr;
    logic [DATA_W-1:0] eng_wdata;
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] chain_idx;
    logic [ADDR_W-1:0] chain_last;
    logic [ADDR_W-1:0] offset_q;
    wl_state_e         state;

    wl_lfsr #(.WIDTH(LFSR_W), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rnd_step),
        .value (lfsr_val)
    );

    wl_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!busy),
        .tick  (tick)
    );

    wl_rotate_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rnd        (lfsr_val[ADDR_W-1:0]),
        .rnd_step   (rnd_step),
        .mem_rdata  (mem_rdata),
        .eng_en     (eng_en),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .commit     (commit),
        .delta      (delta),
        .chain_idx  (chain_idx),
        .chain_last (chain_last),
        .state      (state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (commit) begin
            offset_q <= offset_q + delta;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign req_ready = !busy;

    always_comb begin
        if (busy) begin
            mem_en    = eng_en;
            mem_we    = eng_we;
            mem_addr  = eng_addr;
            mem_wdata = eng_wdata;
        end else begin
            mem_en    = req_valid;
            mem_we    = req_valid && req_write;
            mem_addr  = req_addr + offset_q;
            mem_wdata = req_wdata;
        end
    end

    assign rd_data = mem_rdata;

endmodule

// File: rtl/wl_remapper_chk.sv
module wl_remapper_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              tick,
    input logic              mem_we,
    input logic [ADDR_W-1:0] offset_q,
    input logic [ADDR_W-1:0] delta,
    input logic [ADDR_W-1:0] chain_idx,
    input logic [ADDR_W-1:0] chain_last,
    input wl_pkg::wl_state_e state
);
    import wl_pkg::*;

    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));

    p_tick_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !busy);

    p_step_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_DRAW) |-> (delta != '0));

    p_no_back_to_back_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |=> !mem_we);

    p_offset_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (offset_q == $past(offset_q) + $past(delta)));

    p_chain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_DRAW) |-> ((chain_idx & ~chain_last) == '0));

    p_offset_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_q != $past(offset_q)) |-> $fell(busy));

endmodule

bind wl_remapper wl_remapper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .tick       (tick),
    .mem_we     (mem_we),
    .offset_q   (offset_q),
    .delta      (delta),
    .chain_idx  (chain_idx),
    .chain_last (chain_last),
    .state      (state)
);

// File: tb/wl_remapper_test.sv
module wl_remapper_test;

    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int WORDS  = 1 << AW;
    localparam int PERIOD = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;

    always #5 clk = ~clk;

    // the seed has zero in its low ADDR_W bits, so the first draw is discarded (R4)
    wl_remapper #(.ADDR_W(AW), .DATA_W(DW), .PERIOD(PERIOD), .LFSR_W(16), .SEED(32'h0000_0040)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] shadow [WORDS];
    int            rd_cnt [WORDS];
    int            wr_cnt [WORDS];
    int            edge_cnt = 0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always @(posedge clk) begin
        if (rst_n) edge_cnt <= edge_cnt + 1;
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
        if (busy && mem_en) begin
            if (mem_we) wr_cnt[mem_addr] <= wr_cnt[mem_addr] + 1;
            else        rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
        end
    end

    localparam int NVEC = 8;
    // {logical address, data}
    localparam logic [AW+DW-1:0] VEC [NVEC] = '{
        {6'd0,  16'h1234}, {6'd63, 16'hFFFF}, {6'd1,  16'h0000}, {6'd32, 16'hA5A5},
        {6'd17, 16'h5A5A}, {6'd31, 16'h8001}, {6'd48, 16'h7FFE}, {6'd2,  16'hC3C3}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // write request; returns the physical address it drove (R1)
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output logic [AW-1:0] phys);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        phys = mem_addr;
        check(mem_en && mem_we && mem_wdata == d, "R1", "write port", {mem_en, mem_we}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        shadow[a] = d;
    endtask

    // read request; data is due one falling edge later (R1)
    task automatic do_read(input logic [AW-1:0] a, input string req,
                           output logic [AW-1:0] phys);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        phys = mem_addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_data == shadow[a], req, "read data", rd_data, shadow[a]);
    endtask

    task automatic clear_counts();
        for (int i = 0; i < WORDS; i++) begin
            rd_cnt[i] = 0;
            wr_cnt[i] = 0;
        end
    endtask

    task automatic check_counts();
        int bad;
        bad = 0;
        for (int i = 0; i < WORDS; i++) begin
            if (rd_cnt[i] != 1 || wr_cnt[i] != 1) bad++;
        end
        check(bad == 0, "R5", "words not read and written once", bad, 0);
    endtask

    // reads every logical word; checks data (R6) and a uniform translation
    task automatic readback_all(output logic [AW-1:0] diff);
        logic [AW-1:0] p;
        logic [AW-1:0] d0;
        int            mismatch;
        mismatch = 0;
        d0 = '0;
        for (int a = 0; a < WORDS; a++) begin
            do_read(AW'(a), "R6", p);
            if (a == 0) d0 = p;
            else if (AW'(p - AW'(a)) != d0) mismatch++;
        end
        check(mismatch == 0, "R1", "non-uniform translation", mismatch, 0);
        diff = d0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] p;
        logic [AW-1:0] off1;
        logic [AW-1:0] off2;
        int            fall_e;

        clear_counts();
        for (int i = 0; i < WORDS; i++) mem[i] = '0;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8", "busy in reset", busy, 0);
        check(mem_en == 1'b0, "R8", "mem_en in reset", mem_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && req_ready, "R8", "busy after reset", busy, 0);

        // fill all words; offset is 0 before the first remap (R1, R8)
        for (int a = 0; a < WORDS; a++) begin
            do_write(AW'(a), DW'(a * 613 + 77), p);
            check(p == AW'(a), "R1", "identity map before remap", p, a);
        end

        // stimulus table: write then read back
        for (int v = 0; v < NVEC; v++) begin
            logic [AW-1:0] va;
            va = VEC[v][AW+DW-1:DW];
            do_write(va, VEC[v][DW-1:0], p);
            check(p == va, "R1", "table write address", p, va);
            do_read(va, "R1", p);
            check(p == va, "R1", "table read address", p, va);
        end

        // hold a write across the first remap (R3)
        clear_counts();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd5; req_wdata = 16'hDEAD;
        while (!busy) @(negedge clk);
        check(edge_cnt == PERIOD, "R2", "first remap edge", edge_cnt, PERIOD);
        check(req_ready == 1'b0, "R3", "ready during remap", req_ready, 0);
        while (busy) @(negedge clk);
        fall_e = edge_cnt;
        check(req_ready == 1'b1, "R3", "ready after remap", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        shadow[5] = 16'hDEAD;
        check_counts();

        readback_all(off1);
        check(off1 != '0, "R4", "offset unchanged after first remap", off1, 1);

        // second remap, PERIOD edges after the first ends (R2)
        clear_counts();
        while (!busy) @(negedge clk);
        check(edge_cnt == fall_e + PERIOD, "R2", "second remap edge", edge_cnt, fall_e + PERIOD);
        while (busy) @(negedge clk);
        check(edge_cnt > fall_e + PERIOD + 2 * WORDS, "R7", "remap length", edge_cnt, fall_e + PERIOD + 2 * WORDS);
        check_counts();

        readback_all(off2);
        check(off2 != off1, "R4", "offset unchanged after second remap", off2, off1);
        check(!busy, "R9", "busy after remap", busy, 0);

        finish_run();
    end

endmodule